// File: doc/BRIEF.md
# Flash Program/Erase Command Controller

This block sits between a register bus and a two-bank embedded flash array and runs the two operations the array supports: erasing one page and programming a run of adjacent words. Software loads a small word buffer, describes the target in a transfer register, arms the controller with an unlock key and then writes an operation code into the control register of the bank it wants to change. The controller drives the array's per-bank program and erase strobes and keeps that bank busy for a fixed, parameterised number of cycles.

While a bank is busy, any read of that bank on the memory read port is held with its ready low until the operation has finished. Reads of the other bank are not affected. Mistakes made by software never touch the array: a missing key, an unknown code, a command to a busy bank or a write that would run off the end of the bank are each dropped and leave a mark in an error register that clears itself when it is read.

Top module: `flash_pe_ctrl`

## Requirements
- R1: An operation starts only when 0xB11924E1 was written to the key register (address 0x21) and the next write to a bank's control register (address 0x23 + bank) carries a valid code; that next control write disarms the key whatever its outcome.
- R2: Code 0x31415927 selects page erase and 0x27182818 selects write; a control write with any other value starts nothing and sets error bit 0.
- R3: A control write while the key is not armed starts nothing and sets error bit 0.
- R4: A write programs size+1 words, where size is the zero-based field in bits [20:16] of the transfer register (0x20); buffer entry i goes to word offset+i (offset in bits [15:0]), and the stored word becomes the AND of its old value and the buffer entry.
- R5: An erase sets every word of the 512-word page holding the transfer offset to all ones; the size field is ignored and other pages are untouched.
- R6: A write with offset+size+1 greater than 65536 is rejected and sets error bit 1; one ending exactly at the last word is accepted.
- R7: A bank's control register reads back the running code while busy and 0 otherwise; a write keeps the bank busy for PROG_CYCLES cycles and an erase for ERASE_CYCLES cycles after the accepting edge.
- R8: A read of a busy bank has rd_ready low until the operation ends and then returns the updated word; a read of the other bank is not held.
- R9: A control write to a busy bank, even with the key armed, is ignored, sets error bit 2 and still disarms the key.
- R10: Reading the error register (0x22) returns the accumulated bits and clears them after that read.
- R11: After reset no bank is busy, the error register is 0, the key is disarmed and reads are not held.
- R12: Bit 24 of the transfer register (main/info select) is driven on the bank's arr_info output for the duration of its operation.
- R13: The 32-entry write buffer at addresses 0x00 to 0x1F reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (clears the error register when it addresses it) |
| reg_addr | input | 7 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| rd_req | input | 1 | Memory read request |
| rd_bank | input | 1 | Bank of the memory read |
| rd_addr | input | 16 | Word address of the memory read |
| rd_ready | output | 1 | Read accepted; low while the addressed bank is busy |
| rd_data | output | 32 | Read data |
| arr_rd_bank | output | 1 | Array read bank |
| arr_rd_addr | output | 16 | Array read word address |
| arr_rd_data | input | 32 | Array read data |
| arr_prog | output | 2 | Per-bank program strobe, one word per cycle |
| arr_erase | output | 2 | Per-bank page erase strobe |
| arr_info | output | 2 | Per-bank main/info select during an operation |
| arr_addr | output | 32 | Per-bank word address (16 bits per bank) |
| arr_wdata | output | 64 | Per-bank program data (32 bits per bank) |

## Verification
The assertions watch, on every cycle, that a bank only becomes busy after the key was armed, that every control write disarms the key, that a keyed command to a busy bank raises the busy error, that the error register is empty after it is read, that an erase strobe never lasts more than one cycle and that program strobes walk consecutive addresses. Only the bench scenarios can show the data the array ends up holding (the AND of old and new words, the exact page that an erase clears), the exact stall length seen on the read port, the boundary between an accepted and a rejected write, and the read-back of the control and buffer registers.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;
   localparam int unsigned DW = 32;
   localparam logic [DW-1:0] PE_UNLOCK  = 32'hB119_24E1;
   localparam logic [DW-1:0] OPC_ERASE  = 32'h3141_5927;
   localparam logic [DW-1:0] OPC_WRITE  = 32'h2718_2818;
   localparam int unsigned ERR_W    = 3;
   localparam int unsigned ERR_SEQ  = 0;
   localparam int unsigned ERR_OVF  = 1;
   localparam int unsigned ERR_BUSY = 2;
   localparam int unsigned XF_SIZE_LSB = 16;
   localparam int unsigned XF_INFO_BIT = 24;
endpackage

// File: rtl/fpe_wbuf.sv
module fpe_wbuf #(
   parameter int unsigned DEPTH = 32,
   parameter int unsigned NRD   = 2,
   localparam int unsigned IDX_W = $clog2(DEPTH)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      waddr,
   input  logic [31:0]           wdata,
   input  logic [IDX_W-1:0]      sw_idx,
   output logic [31:0]           sw_data,
   input  logic [NRD*IDX_W-1:0]  eng_idx,
   output logic [NRD*32-1:0]     eng_data
);
   logic [31:0] mem_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[waddr] <= wdata;
      end
   end

   assign sw_data = mem_q[sw_idx];

   for (genvar p = 0; p < NRD; p++) begin : g_port
      assign eng_data[p*32 +: 32] = mem_q[eng_idx[p*IDX_W +: IDX_W]];
   end
endmodule

// File: rtl/fpe_bank_engine.sv
module fpe_bank_engine #(
   parameter int unsigned OFS_W        = 16,
   parameter int unsigned CNT_W        = 5,
   parameter int unsigned PAGE_W       = 9,
   parameter int unsigned PROG_CYCLES  = 48,
   parameter int unsigned ERASE_CYCLES = 64,
   localparam int unsigned MAX_LAT = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
   localparam int unsigned TICK_W  = $clog2(MAX_LAT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_erase,
   input  logic [OFS_W-1:0] start_ofs,
   input  logic [CNT_W-1:0] start_last,
   input  logic             start_info,
   output logic             busy,
   output logic             op_erase,
   output logic [CNT_W-1:0] buf_idx,
   input  logic [31:0]      buf_data,
   output logic             arr_prog,
   output logic             arr_erase,
   output logic             arr_info,
   output logic [OFS_W-1:0] arr_addr,
   output logic [31:0]      arr_wdata
);
   logic             busy_q, erase_q, info_q, issue_q;
   logic [OFS_W-1:0] ofs_q;
   logic [CNT_W-1:0] last_q, idx_q;
   logic [TICK_W-1:0] tick_q, tick_end;

   assign tick_end = erase_q ? TICK_W'(ERASE_CYCLES - 1) : TICK_W'(PROG_CYCLES - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         erase_q <= 1'b0;
         info_q  <= 1'b0;
         issue_q <= 1'b0;
         ofs_q   <= '0;
         last_q  <= '0;
         idx_q   <= '0;
         tick_q  <= '0;
      end else if (start) begin
         busy_q  <= 1'b1;
         erase_q <= start_erase;
         info_q  <= start_info;
         issue_q <= !start_erase;
         ofs_q   <= start_ofs;
         last_q  <= start_last;
         idx_q   <= '0;
         tick_q  <= '0;
      end else if (busy_q) begin
         tick_q <= tick_q + 1'b1;
         if (tick_q == tick_end) begin
            busy_q  <= 1'b0;
            issue_q <= 1'b0;
         end
         if (issue_q) begin
            if (idx_q == last_q) issue_q <= 1'b0;
            else                 idx_q   <= idx_q + 1'b1;
         end
      end
   end

   assign busy      = busy_q;
   assign op_erase  = erase_q;
   assign buf_idx   = idx_q;
   assign arr_prog  = issue_q;
   assign arr_erase = busy_q && erase_q && (tick_q == '0);
   assign arr_info  = busy_q && info_q;
   assign arr_wdata = buf_data;
   assign arr_addr  = erase_q ? {ofs_q[OFS_W-1:PAGE_W], {PAGE_W{1'b0}}}
                              : ofs_q + OFS_W'(idx_q);

   AST_ERASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase |=> !arr_erase); // R5
   AST_PROG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_prog && $past(arr_prog)) |-> (arr_addr == $past(arr_addr) + OFS_W'(1))); // R4
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q); // R9
endmodule

// File: rtl/flash_pe_ctrl.sv
module flash_pe_ctrl
   import flash_pe_pkg::*;
#(
   parameter int unsigned NUM_BANKS    = 2,
   parameter int unsigned BANK_WORDS   = 65536,
   parameter int unsigned PAGE_WORDS   = 512,
   parameter int unsigned BUF_WORDS    = 32,
   parameter int unsigned PROG_CYCLES  = 48,
   parameter int unsigned ERASE_CYCLES = 64,
   localparam int unsigned BK_W   = $clog2(NUM_BANKS),
   localparam int unsigned OFS_W  = $clog2(BANK_WORDS),
   localparam int unsigned CNT_W  = $clog2(BUF_WORDS),
   localparam int unsigned PAGE_W = $clog2(PAGE_WORDS),
   localparam int unsigned ADDR_W = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       reg_we,
   input  logic                       reg_re,
   input  logic [ADDR_W-1:0]          reg_addr,
   input  logic [31:0]                reg_wdata,
   output logic [31:0]                reg_rdata,
   input  logic                       rd_req,
   input  logic [BK_W-1:0]            rd_bank,
   input  logic [OFS_W-1:0]           rd_addr,
   output logic                       rd_ready,
   output logic [31:0]                rd_data,
   output logic [BK_W-1:0]            arr_rd_bank,
   output logic [OFS_W-1:0]           arr_rd_addr,
   input  logic [31:0]                arr_rd_data,
   output logic [NUM_BANKS-1:0]       arr_prog,
   output logic [NUM_BANKS-1:0]       arr_erase,
   output logic [NUM_BANKS-1:0]       arr_info,
   output logic [NUM_BANKS*OFS_W-1:0] arr_addr,
   output logic [NUM_BANKS*32-1:0]    arr_wdata
);
   localparam logic [ADDR_W-1:0] A_XFER  = ADDR_W'(32);
   localparam logic [ADDR_W-1:0] A_KEY   = ADDR_W'(33);
   localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(34);
   localparam int unsigned       A_CTRL0 = 35;

   if (NUM_BANKS < 2 || A_CTRL0 + NUM_BANKS > (1 << ADDR_W)) begin : g_bad_banks
      $error("flash_pe_ctrl: NUM_BANKS out of range");
   end
   if (BUF_WORDS < 2 || BUF_WORDS > 32 || (1 << CNT_W) != BUF_WORDS) begin : g_bad_buf
      $error("flash_pe_ctrl: BUF_WORDS must be a power of two up to 32");
   end
   if ((1 << OFS_W) != BANK_WORDS || OFS_W > XF_SIZE_LSB) begin : g_bad_bank
      $error("flash_pe_ctrl: BANK_WORDS must be a power of two up to 65536");
   end
   if ((1 << PAGE_W) != PAGE_WORDS || PAGE_WORDS >= BANK_WORDS) begin : g_bad_page
      $error("flash_pe_ctrl: PAGE_WORDS must be a power of two below BANK_WORDS");
   end
   if (PROG_CYCLES < BUF_WORDS || ERASE_CYCLES < 1) begin : g_bad_lat
      $error("flash_pe_ctrl: program latency must cover a full buffer");
   end

   logic [OFS_W-1:0]     x_ofs_q;
   logic [CNT_W-1:0]     x_size_q;
   logic                 x_info_q;
   logic                 key_armed;
   logic [ERR_W-1:0]     err_q, err_set;
   logic [NUM_BANKS-1:0] wr_ctrl, eng_start, eng_busy, eng_erase;
   logic                 ctrl_any, busy_hit, opc_ok, wr_ovf, err_clr;
   logic [NUM_BANKS*CNT_W-1:0] eng_idx;
   logic [NUM_BANKS*32-1:0]    eng_data;
   logic [31:0]          buf_sw_data;

   fpe_wbuf #(.DEPTH(BUF_WORDS), .NRD(NUM_BANKS)) u_wbuf (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we && (reg_addr < ADDR_W'(BUF_WORDS))),
      .waddr    (reg_addr[CNT_W-1:0]),
      .wdata    (reg_wdata),
      .sw_idx   (reg_addr[CNT_W-1:0]),
      .sw_data  (buf_sw_data),
      .eng_idx  (eng_idx),
      .eng_data (eng_data)
   );

   assign opc_ok  = (reg_wdata == OPC_ERASE) || (reg_wdata == OPC_WRITE);
   assign wr_ovf  = (reg_wdata == OPC_WRITE) &&
                    ((int'(x_ofs_q) + int'(x_size_q) + 1) > int'(BANK_WORDS));
   assign err_clr = reg_re && (reg_addr == A_ERR);

   always_comb begin
      ctrl_any = |wr_ctrl;
      busy_hit = |(wr_ctrl & eng_busy);
      err_set  = '0;
      if (ctrl_any) begin
         if (!key_armed)    err_set[ERR_SEQ]  = 1'b1;
         else if (busy_hit) err_set[ERR_BUSY] = 1'b1;
         else if (!opc_ok)  err_set[ERR_SEQ]  = 1'b1;
         else if (wr_ovf)   err_set[ERR_OVF]  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_ofs_q   <= '0;
         x_size_q  <= '0;
         x_info_q  <= 1'b0;
         key_armed <= 1'b0;
         err_q     <= '0;
      end else begin
         if (reg_we && reg_addr == A_XFER) begin
            x_ofs_q  <= reg_wdata[OFS_W-1:0];
            x_size_q <= reg_wdata[XF_SIZE_LSB +: CNT_W];
            x_info_q <= reg_wdata[XF_INFO_BIT];
         end
         if (ctrl_any)                       key_armed <= 1'b0;
         else if (reg_we && reg_addr == A_KEY) key_armed <= (reg_wdata == PE_UNLOCK);
         err_q <= (err_clr ? '0 : err_q) | err_set;
      end
   end

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign wr_ctrl[b]   = reg_we && (reg_addr == ADDR_W'(A_CTRL0 + b));
      assign eng_start[b] = wr_ctrl[b] && key_armed && !eng_busy[b] && opc_ok && !wr_ovf;

      fpe_bank_engine #(
         .OFS_W(OFS_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W),
         .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
      ) u_eng (
         .clk         (clk),
         .rst_n       (rst_n),
         .start       (eng_start[b]),
         .start_erase (reg_wdata == OPC_ERASE),
         .start_ofs   (x_ofs_q),
         .start_last  (x_size_q),
         .start_info  (x_info_q),
         .busy        (eng_busy[b]),
         .op_erase    (eng_erase[b]),
         .buf_idx     (eng_idx[b*CNT_W +: CNT_W]),
         .buf_data    (eng_data[b*32 +: 32]),
         .arr_prog    (arr_prog[b]),
         .arr_erase   (arr_erase[b]),
         .arr_info    (arr_info[b]),
         .arr_addr    (arr_addr[b*OFS_W +: OFS_W]),
         .arr_wdata   (arr_wdata[b*32 +: 32])
      );

      AST_START_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(eng_busy[b]) |-> $past(key_armed)); // R1
      AST_BUSY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_ctrl[b] && key_armed && eng_busy[b]) |=> err_q[ERR_BUSY]); // R9
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr < ADDR_W'(BUF_WORDS)) begin
         reg_rdata = buf_sw_data;
      end else if (reg_addr == A_XFER) begin
         reg_rdata[OFS_W-1:0]              = x_ofs_q;
         reg_rdata[XF_SIZE_LSB +: CNT_W]   = x_size_q;
         reg_rdata[XF_INFO_BIT]            = x_info_q;
      end else if (reg_addr == A_ERR) begin
         reg_rdata[ERR_W-1:0] = err_q;
      end else begin
         for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == ADDR_W'(A_CTRL0 + b) && eng_busy[b])
               reg_rdata = eng_erase[b] ? OPC_ERASE : OPC_WRITE;
         end
      end
   end

   assign arr_rd_bank = rd_bank;
   assign arr_rd_addr = rd_addr;
   assign rd_data     = arr_rd_data;
   assign rd_ready    = !rd_req || !eng_busy[rd_bank];

   AST_KEY_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_any |=> !key_armed); // R1
   AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (err_clr && !ctrl_any) |=> (err_q == '0)); // R10
endmodule

// File: tb/test_flash_pe_ctrl.sv
module test_flash_pe_ctrl;
   localparam int PROG  = 48;
   localparam int ERASE = 64;
   localparam logic [31:0] KEY  = 32'hB119_24E1;
   localparam logic [31:0] OPE  = 32'h3141_5927;
   localparam logic [31:0] OPW  = 32'h2718_2818;
   localparam logic [6:0]  A_XFER = 7'h20, A_KEY = 7'h21, A_ERR = 7'h22, A_C0 = 7'h23, A_C1 = 7'h24;

   logic clk = 0, rst_n = 0;
   logic reg_we = 0, reg_re = 0;
   logic [6:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic rd_req = 0, rd_bank = 0, rd_ready;
   logic [15:0] rd_addr = '0;
   logic [31:0] rd_data;
   logic arr_rd_bank;
   logic [15:0] arr_rd_addr;
   logic [31:0] arr_rd_data;
   logic [1:0] arr_prog, arr_erase, arr_info;
   logic [31:0] arr_addr;
   logic [63:0] arr_wdata;

   int checks = 0, fails = 0;
   logic [31:0] exp_q[$];
   string tag_q[$];
   logic [31:0] mem [int];
   logic mem_upd = 0;

   always #2 clk = ~clk;

   flash_pe_ctrl #(.PROG_CYCLES(PROG), .ERASE_CYCLES(ERASE)) i_flash_pe_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rd_req(rd_req), .rd_bank(rd_bank),
      .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data), .arr_rd_bank(arr_rd_bank),
      .arr_rd_addr(arr_rd_addr), .arr_rd_data(arr_rd_data), .arr_prog(arr_prog),
      .arr_erase(arr_erase), .arr_info(arr_info), .arr_addr(arr_addr), .arr_wdata(arr_wdata));

   function automatic logic [31:0] mrd(int k);
      return mem.exists(k) ? mem[k] : 32'hFFFF_FFFF;
   endfunction

   always @(posedge clk) begin
      for (int b = 0; b < 2; b++) begin
         int k;
         k = b * 65536 + int'(arr_addr[b*16 +: 16]);
         if (arr_prog[b]) mem[k] = mrd(k) & arr_wdata[b*32 +: 32];
         if (arr_erase[b]) for (int i = 0; i < 512; i++) mem.delete(k + i);
      end
      mem_upd = ~mem_upd;
   end

   always @(arr_rd_bank or arr_rd_addr or mem_upd)
      arr_rd_data = mrd(int'(arr_rd_bank) * 65536 + int'(arr_rd_addr));

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // scoreboard monitor: pops one expected word per accepted read
   always begin
      @(negedge clk); #1;
      if (rd_req && rd_ready) begin
         if (exp_q.size() == 0) chk(0, "R8 unexpected read", rd_data, 0);
         else chk(rd_data == exp_q[0], tag_q[0], rd_data, exp_q[0]);
         if (exp_q.size() != 0) begin void'(exp_q.pop_front()); void'(tag_q.pop_front()); end
      end
   end

   task automatic wr(input logic [6:0] a, input logic [31:0] d);
      reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
   endtask

   task automatic rr(input logic [6:0] a, output logic [31:0] d);
      reg_re = 1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_re = 0;
   endtask

   task automatic fread(input logic b, input logic [15:0] a, input logic [31:0] exp,
                        input string tag, output int stall);
      rd_req = 1; rd_bank = b; rd_addr = a;
      exp_q.push_back(exp); tag_q.push_back(tag);
      stall = 0;
      forever begin
         #1;
         if (rd_ready) break;
         stall++;
         @(negedge clk);
      end
      @(negedge clk); rd_req = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] xf(input int ofs, input int size, input bit info);
      return {7'b0, info, 3'b0, 5'(size), 16'(ofs)};
   endfunction

   function automatic logic [31:0] pat(input int i);
      return 32'hC3C3_0000 + 32'(i) * 32'h11;
   endfunction

   task automatic finish_test;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      finish_test();
   end

   initial begin
      logic [31:0] d;
      int st;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      rr(A_ERR, d); chk(d == 0, "R11 err after reset", d, 0);
      rr(A_C0, d);  chk(d == 0, "R11 ctrl0 idle", d, 0);
      rd_req = 1; rd_bank = 0; #1 chk(rd_ready == 1, "R11 ready", 32'(rd_ready), 1);
      rd_req = 0; @(negedge clk);
      wr(A_C0, OPW); // R11 key disarmed after reset -> seq error
      rr(A_ERR, d); chk(d == 1, "R11 key disarmed", d, 1);

      // R13 buffer fill and readback
      for (int i = 0; i < 32; i++) wr(7'(i), pat(i));
      rr(7'd5, d);  chk(d == pat(5), "R13 buffer entry 5", d, pat(5));
      rr(7'd31, d); chk(d == pat(31), "R13 buffer entry 31", d, pat(31));

      // R4 / R7 / R8 first write: 4 words at bank0 offset 100
      wr(A_XFER, xf(100, 3, 0));
      wr(A_KEY, KEY);
      wr(A_C0, OPW);
      fread(0, 16'd100, pat(0), "R8 data after stall", st);
      chk(st == PROG, "R7 write stall length", 32'(st), PROG);
      fread(0, 16'd103, pat(3), "R4 last word", st);
      fread(0, 16'd104, 32'hFFFF_FFFF, "R4 word past count", st);

      // R4 second write ANDs with old contents
      for (int i = 0; i < 4; i++) wr(7'(i), 32'h0F0F_F0F0);
      wr(A_KEY, KEY);
      wr(A_C0, OPW);
      rr(A_C0, d); chk(d == OPW, "R7 ctrl reads code while busy", d, OPW);
      idle(PROG);
      rr(A_C0, d); chk(d == 0, "R7 ctrl clears", d, 0);
      fread(0, 16'd101, pat(1) & 32'h0F0F_F0F0, "R4 AND of old and new", st);

      // R5 erase: program across page boundary, erase page 0
      wr(A_XFER, xf(510, 3, 0));
      wr(A_KEY, KEY);
      wr(A_C0, OPW);
      idle(PROG);
      wr(A_XFER, xf(100, 31, 0));
      wr(A_KEY, KEY);
      wr(A_C0, OPE);
      rr(A_C0, d); chk(d == OPE, "R2 erase code read back", d, OPE);
      fread(0, 16'd100, 32'hFFFF_FFFF, "R5 erased word", st);
      chk(st == ERASE - 1, "R7 erase stall length", 32'(st), ERASE - 1);
      fread(0, 16'd511, 32'hFFFF_FFFF, "R5 page end erased", st);
      fread(0, 16'd512, 32'h0F0F_F0F0, "R5 next page kept", st);
      fread(0, 16'd130, 32'hFFFF_FFFF, "R5 size ignored", st);

      // R2 bad opcode
      wr(A_KEY, KEY);
      wr(A_C0, 32'h1234_5678);
      rr(A_C0, d);  chk(d == 0, "R2 bad code starts nothing", d, 0);
      rr(A_ERR, d); chk(d == 1, "R2 bad code error", d, 1);
      rr(A_ERR, d); chk(d == 0, "R10 read clears", d, 0);

      // R3 no key
      wr(A_C1, OPE);
      rr(A_C1, d);  chk(d == 0, "R3 no key no op", d, 0);
      rr(A_ERR, d); chk(d == 1, "R3 seq error", d, 1);

      // R6 overflow and exact fit
      wr(A_XFER, xf(65534, 3, 0));
      wr(A_KEY, KEY);
      wr(A_C1, OPW);
      rr(A_C1, d);  chk(d == 0, "R6 overflow rejected", d, 0);
      rr(A_ERR, d); chk(d == 2, "R6 overflow error", d, 2);
      wr(A_XFER, xf(65532, 3, 0));
      wr(A_KEY, KEY);
      wr(A_C1, OPW);
      rr(A_C1, d);  chk(d == OPW, "R6 exact fit accepted", d, OPW);
      idle(PROG);
      fread(1, 16'd65535, 32'h0F0F_F0F0 & pat(3) | 32'h0F0F_F0F0, "R6 last word written", st);

      // R9 busy error, R8 other bank not stalled
      wr(A_XFER, xf(0, 0, 0));
      wr(A_KEY, KEY);
      wr(A_C1, OPE);
      wr(A_KEY, KEY);
      wr(A_C1, OPW);
      rr(A_C1, d);  chk(d == OPE, "R9 busy bank keeps erase", d, OPE);
      rr(A_ERR, d); chk(d == 4, "R9 busy error", d, 4);
      fread(0, 16'd512, 32'h0F0F_F0F0, "R8 other bank read", st);
      chk(st == 0, "R8 other bank not held", 32'(st), 0);
      idle(ERASE);
      wr(A_C1, OPW);
      rr(A_ERR, d); chk(d == 1, "R9 key consumed by busy write", d, 1);

      // R12 info select
      wr(A_XFER, xf(0, 0, 1));
      wr(A_KEY, KEY);
      wr(A_C0, OPW);
      #1 chk(arr_info == 2'b01, "R12 info driven", 32'(arr_info), 1);
      idle(PROG);
      #1 chk(arr_info == 2'b00, "R12 info drops", 32'(arr_info), 0);
      @(negedge clk);
      rr(A_ERR, d); chk(d == 0, "R1 clean operation no error", d, 0);

      idle(4);
      chk(exp_q.size() == 0, "R8 scoreboard drained", 32'(exp_q.size()), 0);
      finish_test();
   end
endmodule